// File: doc/BRIEF.md
# Crate Event Builder Sequencer

This block sits in a crate controller and assembles one accepted event into a stream of 16-bit words for a transmit FIFO that feeds a data collector. When it sees an accept pulse, it first writes a header word. The header carries a marker nibble and a running event number. It then walks the card slots in ascending order. For each slot it drives the slot number onto the backplane address lines and reads six 16-bit words from that card, one at a time. Each read uses an active-low read strobe and waits for an active-low data-valid answer from the card. After the last slot it writes the beam-clock stamp that was captured at accept time. A trailer word closes the event and reports whether any card failed to answer.

A card that does not answer within a bounded number of cycles does not stall the crate. The word that timed out and all the rest of that card's words are written as 0xFFFF, and no further strobes go to that card. Every FIFO write waits while the FIFO reports full, so no word is lost or repeated. The state machine has six states:
- IDLE waits for accept.
- HEAD writes the header.
- STROBE holds the read strobe low until data-valid arrives or the time limit runs out.
- PUSH writes the captured or filler word.
- STAMP writes the beam-clock value.
- TRAIL writes the trailer.

Each state moves to the next one named below, on the condition given:
- IDLE to HEAD on accept.
- HEAD to STROBE once the header is written.
- STROBE to PUSH on data-valid or on timeout.
- PUSH to STROBE for the next word or the next slot.
- PUSH to PUSH for the remaining filler words of a timed-out card.
- PUSH to STAMP after the last word of the last slot.
- STAMP to TRAIL once the stamp is written.
- TRAIL to IDLE once the trailer is written.

Top module: `evb_sequencer`

## Requirements
- R1: After reset, and whenever the block is idle, `busy_o` is 0, `rd_n_o` is 1 and `fifo_we_o` is 0.
- R2: The first word of each event is {4'hA, event number[11:0]}. The event number is 0 for the first event after reset and rises by 1 for each event built, wrapping at 12 bits.
- R3: Slots are visited in order 0 to NUM_SLOTS-1. `slot_addr_o` holds the current slot number for as long as `rd_n_o` is low.
- R4: Each slot gives WORDS_PER_SLOT words, the least significant word first, with one strobe per word. `rd_n_o` stays low until `dv_n_i` is seen low at a clock edge, and it is high for at least one cycle before the next strobe. The word written is the `bus_data_i` value sampled at that edge.
- R5: If `dv_n_i` is not seen low in TIMEOUT_CYC consecutive strobe cycles, the strobe is released. That word and every later word of the same card are written as 0xFFFF, and that card gets no further strobes in this event. A card that answers in the last allowed cycle is accepted.
- R6: After the last card's words, the block writes the 16-bit value that was on `bcnt_i` in the cycle `accept_i` was taken.
- R7: The last word is the trailer {4'hC, err, 3'b000, nbad[7:0]}. Here err is 1 if any card timed out, and nbad is the number of cards that timed out.
- R8: `fifo_we_o` is never high while `fifo_full_i` is high. A word that is waiting on a full FIFO stays on `fifo_data_o` until it is written, so no word is dropped or duplicated.
- R9: `busy_o` rises in the cycle after `accept_i` is taken in IDLE. `accept_i` has no effect while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| accept_i | input | 1 | Start building one event |
| bcnt_i | input | 16 | Beam-clock counter value, captured at accept |
| busy_o | output | 1 | An event is being built |
| slot_addr_o | output | SLOT_AW | Backplane slot address |
| rd_n_o | output | 1 | Active-low read strobe to the card |
| dv_n_i | input | 1 | Active-low data-valid from the card |
| bus_data_i | input | 16 | Backplane data bus |
| fifo_full_i | input | 1 | Transmit FIFO is full |
| fifo_we_o | output | 1 | Transmit FIFO write enable |
| fifo_data_o | output | 16 | Transmit FIFO write data |

## Verification
The bench builds the block with NUM_SLOTS=3 and TIMEOUT_CYC=6, and keeps six words per slot. With these values a single event fits in a few dozen cycles, so many events can be run in one pass. This brings several cases within reach:
- A card that answers in the very last allowed strobe cycle.
- A card that dies partway through its six words.
- A crate where every card is dead.
- Long runs with the FIFO full.

The short card count also lets the bench check that the event number keeps incrementing from event to event, and that a second accept arriving mid-event is ignored.

// File: rtl/evb_pkg.sv
package evb_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_HEAD,
        S_STROBE,
        S_PUSH,
        S_STAMP,
        S_TRAIL
    } evb_state_e;

    localparam logic [3:0]  HEAD_MARK = 4'hA;
    localparam logic [3:0]  TRL_MARK  = 4'hC;
    localparam logic [15:0] FILL_WORD = 16'hFFFF;

    function automatic logic [15:0] make_header(input logic [11:0] evno);
        return {HEAD_MARK, evno};
    endfunction

    function automatic logic [15:0] make_trailer(input logic err, input logic [7:0] nbad);
        return {TRL_MARK, err, 3'b000, nbad};
    endfunction

endpackage

// File: rtl/evb_index_ctr.sv
module evb_index_ctr #(
    parameter int NUM_SLOTS      = 20,
    parameter int WORDS_PER_SLOT = 6,
    parameter int SLOT_AW        = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               step_word,
    input  logic               step_slot,
    output logic [SLOT_AW-1:0] slot_o,
    output logic               last_word_o,
    output logic               last_slot_o
);
    localparam int WW = (WORDS_PER_SLOT > 1) ? $clog2(WORDS_PER_SLOT) : 1;
    localparam logic [WW-1:0]      LAST_W = WW'(WORDS_PER_SLOT - 1);
    localparam logic [SLOT_AW-1:0] LAST_S = SLOT_AW'(NUM_SLOTS - 1);

    logic [WW-1:0]      word_q;
    logic [SLOT_AW-1:0] slot_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            word_q <= '0;
            slot_q <= '0;
        end else if (step_slot) begin
            word_q <= '0;
            slot_q <= slot_q + 1'b1;
        end else if (step_word) begin
            word_q <= word_q + 1'b1;
        end
    end

    assign slot_o      = slot_q;
    assign last_word_o = (word_q == LAST_W);
    assign last_slot_o = (slot_q == LAST_S);
endmodule

// File: rtl/evb_timeout.sv
module evb_timeout #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired_o
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired_o = run && (cnt_q == LAST);
endmodule

// File: rtl/evb_event_ctr.sv
module evb_event_ctr #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_o <= '0;
        end else if (inc) begin
            count_o <= count_o + 1'b1;
        end
    end
endmodule

// File: rtl/evb_sequencer.sv
module evb_sequencer
    import evb_pkg::*;
#(
    parameter int NUM_SLOTS      = 20,
    parameter int WORDS_PER_SLOT = 6,
    parameter int SLOT_AW        = 5,
    parameter int TIMEOUT_CYC    = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               accept_i,
    input  logic [15:0]        bcnt_i,
    output logic               busy_o,
    output logic [SLOT_AW-1:0] slot_addr_o,
    output logic               rd_n_o,
    input  logic               dv_n_i,
    input  logic [15:0]        bus_data_i,
    input  logic               fifo_full_i,
    output logic               fifo_we_o,
    output logic [15:0]        fifo_data_o
);
    localparam int EVW = 12;

    evb_state_e st, nst;

    logic [15:0]    word_q;
    logic [15:0]    bcnt_q;
    logic [7:0]     nbad_q;
    logic           card_bad_q;
    logic [EVW-1:0] evno;

    logic idx_clr, step_word, step_slot, last_word, last_slot;
    logic tmo, cap, tmo_hit, evt_inc, start;
    logic in_write;

    evb_index_ctr #(
        .NUM_SLOTS(NUM_SLOTS),
        .WORDS_PER_SLOT(WORDS_PER_SLOT),
        .SLOT_AW(SLOT_AW)
    ) u_idx (
        .clk(clk), .rst_n(rst_n), .clr(idx_clr),
        .step_word(step_word), .step_slot(step_slot),
        .slot_o(slot_addr_o), .last_word_o(last_word), .last_slot_o(last_slot)
    );

    evb_timeout #(.LIMIT(TIMEOUT_CYC)) u_tmo (
        .clk(clk), .rst_n(rst_n), .run(st == S_STROBE), .expired_o(tmo)
    );

    evb_event_ctr #(.W(EVW)) u_evt (
        .clk(clk), .rst_n(rst_n), .inc(evt_inc), .count_o(evno)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= nst;
    end

    // next state and sequencing strobes
    always_comb begin
        nst       = st;
        idx_clr   = 1'b0;
        step_word = 1'b0;
        step_slot = 1'b0;
        cap       = 1'b0;
        tmo_hit   = 1'b0;
        evt_inc   = 1'b0;
        start     = 1'b0;
        unique case (st)
            S_IDLE: begin
                if (accept_i) begin
                    start   = 1'b1;
                    idx_clr = 1'b1;
                    nst     = S_HEAD;
                end
            end
            S_HEAD: begin
                if (!fifo_full_i) nst = S_STROBE;
            end
            S_STROBE: begin
                if (!dv_n_i) begin
                    cap = 1'b1;
                    nst = S_PUSH;
                end else if (tmo) begin
                    tmo_hit = 1'b1;
                    nst     = S_PUSH;
                end
            end
            S_PUSH: begin
                if (!fifo_full_i) begin
                    if (last_word) begin
                        if (last_slot) begin
                            nst = S_STAMP;
                        end else begin
                            step_slot = 1'b1;
                            nst       = S_STROBE;
                        end
                    end else begin
                        step_word = 1'b1;
                        nst       = card_bad_q ? S_PUSH : S_STROBE;
                    end
                end
            end
            S_STAMP: begin
                if (!fifo_full_i) nst = S_TRAIL;
            end
            S_TRAIL: begin
                if (!fifo_full_i) begin
                    evt_inc = 1'b1;
                    nst     = S_IDLE;
                end
            end
            default: nst = S_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q     <= '0;
            bcnt_q     <= '0;
            nbad_q     <= '0;
            card_bad_q <= 1'b0;
        end else begin
            if (start) begin
                bcnt_q     <= bcnt_i;
                nbad_q     <= '0;
                card_bad_q <= 1'b0;
            end
            if (cap) word_q <= bus_data_i;
            if (tmo_hit) begin
                word_q     <= FILL_WORD;
                card_bad_q <= 1'b1;
                nbad_q     <= nbad_q + 1'b1;
            end
            if (step_slot) card_bad_q <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        busy_o      = (st != S_IDLE);
        rd_n_o      = 1'b1;
        in_write    = 1'b0;
        fifo_data_o = '0;
        unique case (st)
            S_IDLE:   ;
            S_HEAD:   begin in_write = 1'b1; fifo_data_o = make_header(evno); end
            S_STROBE: rd_n_o = 1'b0;
            S_PUSH:   begin in_write = 1'b1; fifo_data_o = word_q; end
            S_STAMP:  begin in_write = 1'b1; fifo_data_o = bcnt_q; end
            S_TRAIL:  begin in_write = 1'b1; fifo_data_o = make_trailer(nbad_q != 0, nbad_q); end
            default:  ;
        endcase
        fifo_we_o = in_write && !fifo_full_i;
    end
endmodule

// File: rtl/evb_sequencer_chk.sv
module evb_sequencer_chk #(
    parameter int SLOT_AW     = 5,
    parameter int TIMEOUT_CYC = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               accept_i,
    input logic               busy_o,
    input logic [SLOT_AW-1:0] slot_addr_o,
    input logic               rd_n_o,
    input logic               dv_n_i,
    input logic               fifo_full_i,
    input logic               fifo_we_o,
    input logic [15:0]        fifo_data_o,
    input logic               in_write
);
    localparam int LW = $clog2(TIMEOUT_CYC + 1);
    logic [LW-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || rd_n_o) low_cnt <= '0;
        else                  low_cnt <= low_cnt + 1'b1;
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (rd_n_o && !fifo_we_o));

    assert_header_mark_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (fifo_data_o[15:12] == 4'hA));

    assert_slot_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n_o && $past(!rd_n_o)) |-> $stable(slot_addr_o));

    assert_strobe_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n_o && !dv_n_i) |=> rd_n_o);

    assert_strobe_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n_o |-> (low_cnt < LW'(TIMEOUT_CYC)));

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full_i |-> !fifo_we_o);

    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_write && fifo_full_i) |=> (in_write && $stable(fifo_data_o)));

    assert_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && accept_i) |=> busy_o);
endmodule

bind evb_sequencer evb_sequencer_chk #(
    .SLOT_AW(SLOT_AW),
    .TIMEOUT_CYC(TIMEOUT_CYC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .accept_i(accept_i), .busy_o(busy_o),
    .slot_addr_o(slot_addr_o), .rd_n_o(rd_n_o), .dv_n_i(dv_n_i),
    .fifo_full_i(fifo_full_i), .fifo_we_o(fifo_we_o),
    .fifo_data_o(fifo_data_o), .in_write(in_write)
);

// File: tb/tb_evb_sequencer.sv
module tb_evb_sequencer;
    localparam int NS  = 3;
    localparam int WPS = 6;
    localparam int AW  = 5;
    localparam int TMO = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          accept_i = 1'b0;
    logic [15:0]   bcnt_i = '0;
    logic          busy_o;
    logic [AW-1:0] slot_addr_o;
    logic          rd_n_o;
    logic          dv_n_i = 1'b1;
    logic [15:0]   bus_data_i = '0;
    logic          fifo_full_i = 1'b0;
    logic          fifo_we_o;
    logic [15:0]   fifo_data_o;

    evb_sequencer #(.NUM_SLOTS(NS), .WORDS_PER_SLOT(WPS), .SLOT_AW(AW), .TIMEOUT_CYC(TMO)) dut (
        .clk(clk), .rst_n(rst_n), .accept_i(accept_i), .bcnt_i(bcnt_i),
        .busy_o(busy_o), .slot_addr_o(slot_addr_o), .rd_n_o(rd_n_o),
        .dv_n_i(dv_n_i), .bus_data_i(bus_data_i), .fifo_full_i(fifo_full_i),
        .fifo_we_o(fifo_we_o), .fifo_data_o(fifo_data_o)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int fails  = 0;

    logic [15:0] exp_q[$];
    int          tag_q[$];

    int  die_after [NS];
    int  lat       [NS];
    int  widx      [NS];
    int  ev_no     = 0;
    int  cur_ev    = 0;
    bit  full_mode = 1'b0;
    logic [7:0] lfsr = 8'h5B;

    function automatic logic [15:0] pat(int ev, int s, int w);
        return 16'(ev * 16'h1111 + s * 16'h0203 + w * 16'h0010 + 16'h0007);
    endfunction

    task automatic check(bit ok, int req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
        end
    endtask

    // card responder and FIFO full driver, driven after each edge
    int  lowc = 0;
    int  last_s = 0;
    bit  was_low = 1'b0;
    bit  answered = 1'b0;
    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        fifo_full_i = full_mode ? lfsr[0] : 1'b0;
        if (!rd_n_o) begin
            last_s = int'(slot_addr_o);
            lowc++;
            was_low = 1'b1;
            if (last_s < NS && widx[last_s] < die_after[last_s] && lowc > lat[last_s]) begin
                dv_n_i     = 1'b0;
                bus_data_i = pat(cur_ev, last_s, widx[last_s]);
                answered   = 1'b1;
            end else begin
                dv_n_i = 1'b1;
            end
        end else begin
            if (was_low) begin
                if (answered) widx[last_s]++;
                else check(lowc == TMO, 5, 16'(lowc), 16'(TMO)); // R5 strobe length on timeout
            end
            was_low  = 1'b0;
            answered = 1'b0;
            lowc     = 0;
            dv_n_i   = 1'b1;
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (fifo_full_i && fifo_we_o) check(1'b0, 8, 16'h1, 16'h0); // R8
            if (fifo_we_o) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, 8, fifo_data_o, 16'h0); // R8 extra word
                end else begin
                    logic [15:0] e;
                    int t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(fifo_data_o == e, t, fifo_data_o, e);
                end
            end
        end
    end

    task automatic push(logic [15:0] v, int tag);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    // driver: build expected stream, run one event
    task automatic run_event(logic [15:0] bc, bit fm, bit second_accept);
        int nbad = 0;
        push({4'hA, 12'(ev_no)}, 2);                    // R2 header
        for (int s = 0; s < NS; s++) begin
            if (die_after[s] < WPS) nbad++;
            for (int w = 0; w < WPS; w++)               // R3 R4 order, R5 fill
                push((w < die_after[s]) ? pat(ev_no, s, w) : 16'hFFFF,
                     (w < die_after[s]) ? 4 : 5);
        end
        push(bc, 6);                                    // R6 stamp
        push({4'hC, (nbad != 0), 3'b000, 8'(nbad)}, 7); // R7 trailer
        for (int s = 0; s < NS; s++) widx[s] = 0;
        cur_ev = ev_no;
        full_mode = fm;
        @(posedge clk); #1;
        accept_i = 1'b1;
        bcnt_i   = bc;
        @(posedge clk); #1;
        accept_i = 1'b0;
        bcnt_i   = 16'hDEAD;
        @(negedge clk);
        check(busy_o == 1'b1, 9, 16'(busy_o), 16'h1);   // R9 busy rises
        if (second_accept) begin
            repeat (5) @(posedge clk);
            #1 accept_i = 1'b1;                         // R9 must be ignored
            @(posedge clk); #1 accept_i = 1'b0;
        end
        while (busy_o) @(negedge clk);
        full_mode = 1'b0;
        check(exp_q.size() == 0, 8, 16'(exp_q.size()), 16'h0); // R8 nothing lost
        repeat (3) @(negedge clk);
        check(!busy_o && rd_n_o && !fifo_we_o, 1, 16'(busy_o), 16'h0); // R1 idle again
        ev_no++;
    endtask

    initial begin : wdog
        repeat (50000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        for (int s = 0; s < NS; s++) begin
            die_after[s] = WPS;
            lat[s] = 0;
            widx[s] = 0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(busy_o == 1'b0, 1, 16'(busy_o), 16'h0);
        check(rd_n_o == 1'b1, 1, 16'(rd_n_o), 16'h1);
        check(fifo_we_o == 1'b0, 1, 16'(fifo_we_o), 16'h0);

        // all cards answer at once, FIFO free
        run_event(16'h1234, 1'b0, 1'b0);

        // varied latency including last allowed cycle (R5 boundary), FIFO back-pressure (R8)
        lat[0] = 2; lat[1] = TMO - 1; lat[2] = 1;
        run_event(16'hBEEF, 1'b1, 1'b0);

        // one dead card and one dying mid-card (R5, R7)
        lat[0] = 0; lat[1] = 0; lat[2] = 3;
        die_after[1] = 0; die_after[2] = 3;
        run_event(16'h0F0F, 1'b1, 1'b0);

        // every card dead
        for (int s = 0; s < NS; s++) die_after[s] = 0;
        run_event(16'h8001, 1'b0, 1'b0);

        // healthy again, extra accept mid-event ignored (R9)
        for (int s = 0; s < NS; s++) begin
            die_after[s] = WPS;
            lat[s] = s;
        end
        run_event(16'h4242, 1'b1, 1'b1);

        // following event number continues by one (R2)
        run_event(16'h0001, 1'b0, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule